// File: doc/BRIEF.md
# Cell Receive Header Checker and Channel Router

This block sits on the receive side of a circuit-emulation path. It takes fixed-length 53-byte cells one byte per clock and reads the path and circuit identifiers from the cell header. It looks these identifiers up in a small programmable table to find a local channel. Cells with no valid table entry are dropped. For a matching cell, the adaptation header byte that follows the cell header is checked for errors. A single-bit error is repaired, and a header that cannot be repaired causes the whole cell to be discarded.

After the header passes, its 3-bit sequence count is compared with the count expected for that channel. The channel's timing-indication bit is reported together with the channel index. The 47 payload bytes are then written through a byte write port into the channel's 47-byte slot of an external payload memory. Once the last byte is written, the channel's ready flag is raised. The ready flag stays high until the consumer clears it.

Top module: `cell_rx_router`

## Requirements
- R1: A cell whose identifiers match no valid table entry produces a one-cycle `cell_miss` pulse. It produces no payload write, no `csi_valid`, no ready flag and no sequence-state change.
- R2: Table entry `tbl_idx` is written with valid, VPI, VCI and channel when `tbl_we` is high. All entries are invalid after reset. A cell matches an entry only when the valid bit is set and both the 8-bit VPI and the 16-bit VCI are equal. The lowest-index matching entry wins. The header packs these fields as: byte0[3:0]=VPI[7:4], byte1[7:4]=VPI[3:0], byte1[3:0]=VCI[15:12], byte2=VCI[11:4], byte3[7:4]=VCI[3:0].
- R3: Byte 5 of the cell is the adaptation header. Bit 7 is CSI and bits 6:4 are the sequence count. Bits 3:1 are the remainder of {CSI,SC}·x^3 divided by x^3+x+1. Bit 0 makes the parity of the whole byte even. A header with this exact form is accepted without a `hdr_fix` pulse.
- R4: A header with exactly one flipped bit, in any of the eight positions, is accepted with a `hdr_fix` pulse. Its corrected CSI and sequence count are used.
- R5: A header with even overall parity and a nonzero check remainder produces a `hdr_bad` pulse. The cell is discarded, and no channel state changes.
- R6: Per channel, the expected count is the last accepted count plus one, modulo 8. The first accepted cell after reset is never flagged. A mismatch gives a one-cycle pulse on `seq_err[channel]`, and the expected count is resynchronised to the received count plus one.
- R7: An accepted cell's payload byte k (cell byte 6+k, k=0..46) is written one cycle after it is taken, at address channel*47+k, with its value on `wr_data`.
- R8: `rdy[channel]` rises one cycle after the last payload write of an accepted cell. It stays high until the matching `rdy_clr` bit is pulsed. All flags are clear after reset.
- R9: One cycle after an accepted header byte is taken, `csi_valid` pulses for one cycle, with the corrected CSI on `csi_bit` and the channel on `csi_chan`.
- R10: Bytes are taken only when `in_valid` is high, so idle cycles inside a cell stall it. A new `in_sop` restarts byte counting, and the abandoned cell never raises a ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Cell byte present |
| in_sop | input | 1 | Marks byte 0 of a cell |
| in_byte | input | 8 | Cell byte |
| tbl_we | input | 1 | Lookup table write strobe |
| tbl_idx | input | ENT_W | Table entry to write |
| tbl_valid | input | 1 | Valid bit for the entry |
| tbl_vpi | input | 8 | VPI key |
| tbl_vci | input | 16 | VCI key |
| tbl_chan | input | CH_W | Channel returned on a match |
| wr_en | output | 1 | Payload memory write strobe |
| wr_addr | output | ADDR_W | Payload memory address |
| wr_data | output | 8 | Payload byte |
| rdy | output | NCH | Per-channel payload-ready flags |
| rdy_clr | input | NCH | Per-channel ready-flag clear |
| csi_valid | output | 1 | Accepted-header strobe |
| csi_bit | output | 1 | Corrected CSI bit |
| csi_chan | output | CH_W | Channel of the accepted header |
| seq_err | output | NCH | Per-channel sequence mismatch pulse |
| hdr_fix | output | 1 | Single-bit header error repaired |
| hdr_bad | output | 1 | Unrepairable header, cell dropped |
| cell_miss | output | 1 | No valid table match, cell dropped |

## Verification
Properties check on every cycle that payload writes inside a cell run to consecutive in-range addresses. They also check that a miss or an unrepairable header never coincides with an accepted-header strobe, that at most one sequence error fires at a time, and that a ready flag only rises just after a write. Whether the repaired count really equals the transmitted one, and whether a dropped cell left the expected count untouched, only show up in the bench's scenarios, which compare outputs against independently built headers. The same holds for table keying on both identifiers, and for the handling of stalls and aborted cells.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;

    localparam int PAY_BYTES = 47;
    localparam int IDX_W     = 6;

    localparam logic [IDX_W-1:0] IDX_AAL  = 6'd5;
    localparam logic [IDX_W-1:0] IDX_PAY0 = 6'd6;
    localparam logic [IDX_W-1:0] IDX_LAST = 6'd52;
    localparam logic [IDX_W-1:0] IDX_IDLE = 6'd53;

    typedef struct packed {
        logic        valid;
        logic [7:0]  vpi;
        logic [15:0] vci;
    } key_ent_t;

    typedef struct packed {
        logic       csi;
        logic [2:0] sc;
    } sn_t;

    typedef struct packed {
        logic ok;
        logic fixed;
        sn_t  sn;
    } snp_res_t;

    // remainder of d(x)*x^3 modulo x^3+x+1, shifted in MSB first
    function automatic logic [2:0] crc3(input logic [3:0] d);
        logic [2:0] r;
        logic       fb;
        r = '0;
        for (int i = 3; i >= 0; i--) begin
            fb = d[i] ^ r[2];
            r  = {r[1:0], 1'b0} ^ {1'b0, fb, fb};
        end
        return r;
    endfunction

endpackage

// File: rtl/cellrx_lookup.sv
module cellrx_lookup
    import cellrx_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int CH_W    = 2,
    parameter int ENT_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [ENT_W-1:0] widx,
    input  logic             wvalid,
    input  logic [7:0]       wvpi,
    input  logic [15:0]      wvci,
    input  logic [CH_W-1:0]  wchan,
    input  logic [7:0]       vpi,
    input  logic [15:0]      vci,
    output logic             hit,
    output logic [CH_W-1:0]  chan
);

    key_ent_t            keys  [ENTRIES];
    logic [CH_W-1:0]     chans [ENTRIES];
    logic [ENTRIES-1:0]  match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                keys[e]  <= '0;
                chans[e] <= '0;
            end else if (we && widx == ENT_W'(e)) begin
                keys[e]  <= '{valid: wvalid, vpi: wvpi, vci: wvci};
                chans[e] <= wchan;
            end
        end
        assign match[e] = keys[e].valid && keys[e].vpi == vpi && keys[e].vci == vci;
    end

    always_comb begin
        hit  = 1'b0;
        chan = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match[e]) begin
                hit  = 1'b1;
                chan = chans[e];
            end
        end
    end

endmodule

// File: rtl/cellrx_snp.sv
module cellrx_snp
    import cellrx_pkg::*;
(
    input  logic [7:0] hdr,
    output snp_res_t   res
);

    logic       par;
    logic [2:0] syn;
    logic [7:0] cw;
    logic [7:0] trial;
    logic       ok;
    logic       fixed;

    always_comb begin
        par   = ^hdr;
        syn   = crc3(hdr[7:4]) ^ hdr[3:1];
        cw    = hdr;
        trial = hdr;
        ok    = 1'b1;
        fixed = 1'b0;
        if (syn != 3'd0 && !par) begin
            ok = 1'b0;
        end else if (par) begin
            fixed = 1'b1;
            if (syn != 3'd0) begin
                for (int i = 1; i < 8; i++) begin
                    trial = hdr ^ (8'd1 << i);
                    if (crc3(trial[7:4]) == trial[3:1]) cw = trial;
                end
            end
        end
        res = '{ok: ok, fixed: fixed, sn: cw[7:4]};
    end

endmodule

// File: rtl/cellrx_seq.sv
module cellrx_seq #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            chk,
    input  logic [CH_W-1:0] ch,
    input  logic [2:0]      sc,
    output logic [NCH-1:0]  err
);

    logic [2:0]     exp_q  [NCH];
    logic [NCH-1:0] sync_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                exp_q[c]  <= '0;
                sync_q[c] <= 1'b0;
                err[c]    <= 1'b0;
            end else begin
                err[c] <= 1'b0;
                if (chk && ch == CH_W'(c)) begin
                    err[c]    <= sync_q[c] && (sc != exp_q[c]);
                    exp_q[c]  <= sc + 3'd1;
                    sync_q[c] <= 1'b1;
                end
            end
        end
    end

    // R6
    one_seq_err_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(err));

endmodule

// File: rtl/cell_rx_router.sv
module cell_rx_router
    import cellrx_pkg::*;
#(
    parameter  int NCH     = 4,
    parameter  int ENTRIES = 4,
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int ENT_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int ADDR_W  = $clog2(NCH * PAY_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [7:0]        in_byte,
    input  logic              tbl_we,
    input  logic [ENT_W-1:0]  tbl_idx,
    input  logic              tbl_valid,
    input  logic [7:0]        tbl_vpi,
    input  logic [15:0]       tbl_vci,
    input  logic [CH_W-1:0]   tbl_chan,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [NCH-1:0]    rdy,
    input  logic [NCH-1:0]    rdy_clr,
    output logic              csi_valid,
    output logic              csi_bit,
    output logic [CH_W-1:0]   csi_chan,
    output logic [NCH-1:0]    seq_err,
    output logic              hdr_fix,
    output logic              hdr_bad,
    output logic              cell_miss
);

    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(PAY_BYTES);

    logic [IDX_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic             take;
    logic [7:0]       vpi_q;
    logic [15:0]      vci_q;
    logic             hit_q;
    logic [CH_W-1:0]  chan_q;
    logic             active;
    logic             done_q;
    logic             lk_hit;
    logic [CH_W-1:0]  lk_chan;
    snp_res_t         snp;
    logic             seq_chk;

    assign idx     = in_sop ? '0 : cnt;
    assign take    = in_valid && (in_sop || cnt <= IDX_LAST);
    assign seq_chk = take && idx == IDX_AAL && hit_q && snp.ok;

    cellrx_lookup #(.ENTRIES(ENTRIES), .CH_W(CH_W), .ENT_W(ENT_W)) u_lookup (
        .clk(clk), .rst(rst), .we(tbl_we), .widx(tbl_idx), .wvalid(tbl_valid),
        .wvpi(tbl_vpi), .wvci(tbl_vci), .wchan(tbl_chan),
        .vpi(vpi_q), .vci(vci_q), .hit(lk_hit), .chan(lk_chan)
    );

    cellrx_snp u_snp (.hdr(in_byte), .res(snp));

    cellrx_seq #(.NCH(NCH), .CH_W(CH_W)) u_seq (
        .clk(clk), .rst(rst), .chk(seq_chk), .ch(chan_q), .sc(snp.sn.sc), .err(seq_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= IDX_IDLE;
            vpi_q     <= '0;
            vci_q     <= '0;
            hit_q     <= 1'b0;
            chan_q    <= '0;
            active    <= 1'b0;
            done_q    <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            csi_valid <= 1'b0;
            csi_bit   <= 1'b0;
            csi_chan  <= '0;
            hdr_fix   <= 1'b0;
            hdr_bad   <= 1'b0;
            cell_miss <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            done_q    <= 1'b0;
            csi_valid <= 1'b0;
            hdr_fix   <= 1'b0;
            hdr_bad   <= 1'b0;
            cell_miss <= 1'b0;
            if (take) begin
                cnt <= idx + 1'b1;
                case (idx)
                    6'd0: begin vpi_q[7:4] <= in_byte[3:0]; active <= 1'b0; end
                    6'd1: begin vpi_q[3:0] <= in_byte[7:4]; vci_q[15:12] <= in_byte[3:0]; end
                    6'd2: vci_q[11:4] <= in_byte;
                    6'd3: vci_q[3:0]  <= in_byte[7:4];
                    6'd4: begin hit_q <= lk_hit; chan_q <= lk_chan; end
                    default: ;
                endcase
                if (idx == IDX_AAL) begin
                    if (!hit_q) begin
                        cell_miss <= 1'b1;
                    end else if (!snp.ok) begin
                        hdr_bad <= 1'b1;
                    end else begin
                        active    <= 1'b1;
                        hdr_fix   <= snp.fixed;
                        csi_valid <= 1'b1;
                        csi_bit   <= snp.sn.csi;
                        csi_chan  <= chan_q;
                    end
                end
                if (idx >= IDX_PAY0 && active) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ADDR_W'(chan_q) * SLOT + ADDR_W'(idx - IDX_PAY0);
                    wr_data <= in_byte;
                    done_q  <= (idx == IDX_LAST);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdy <= '0;
        else     rdy <= (rdy & ~rdy_clr) | (done_q ? (NCH'(1) << chan_q) : '0);
    end

    // R7
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_addr < ADDR_W'(NCH * PAY_BYTES));
    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + 1'b1);
    // R1
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cell_miss |-> !csi_valid && !hdr_bad && !hdr_fix);
    // R5
    bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_bad |-> !csi_valid && !hdr_fix);
    // R9
    csi_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        csi_valid |-> $past(in_valid));

    for (genvar c = 0; c < NCH; c++) begin : g_rdy_chk
        // R8
        rdy_rise_chk: assert property (@(posedge clk) disable iff (rst)
            rdy[c] && !$past(rdy[c]) |-> $past(wr_en));
    end

endmodule

// File: tb/cell_rx_router_test.sv
module cell_rx_router_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_idx = '0;
    logic        tbl_valid = 1'b0;
    logic [7:0]  tbl_vpi = '0;
    logic [15:0] tbl_vci = '0;
    logic [1:0]  tbl_chan = '0;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [3:0]  rdy;
    logic [3:0]  rdy_clr = '0;
    logic        csi_valid;
    logic        csi_bit;
    logic [1:0]  csi_chan;
    logic [3:0]  seq_err;
    logic        hdr_fix;
    logic        hdr_bad;
    logic        cell_miss;

    always #5 clk = ~clk;

    cell_rx_router uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_byte(in_byte),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid), .tbl_vpi(tbl_vpi),
        .tbl_vci(tbl_vci), .tbl_chan(tbl_chan), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rdy(rdy), .rdy_clr(rdy_clr), .csi_valid(csi_valid),
        .csi_bit(csi_bit), .csi_chan(csi_chan), .seq_err(seq_err), .hdr_fix(hdr_fix),
        .hdr_bad(hdr_bad), .cell_miss(cell_miss)
    );

    int checks = 0;
    int fails  = 0;

    // monitor state
    int         wcnt, wbad, csi_n, fix_n, bad_n, miss_n;
    logic       csi_seen;
    logic [1:0] csich_seen;
    logic [3:0] serr_seen;
    int         mon_ch, mon_seed;

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                if (wr_addr != 8'(mon_ch * 47 + wcnt) || wr_data != 8'(mon_seed + wcnt)) wbad++;
                wcnt++;
            end
            if (csi_valid) begin
                csi_n++;
                csi_seen   = csi_bit;
                csich_seen = csi_chan;
            end
            serr_seen = serr_seen | seq_err;
            if (hdr_fix)   fix_n++;
            if (hdr_bad)   bad_n++;
            if (cell_miss) miss_n++;
        end
    end

    task automatic mon_reset(input int ch, input int seed);
        wcnt = 0; wbad = 0; csi_n = 0; fix_n = 0; bad_n = 0; miss_n = 0;
        csi_seen = 1'b0; csich_seen = '0; serr_seen = '0;
        mon_ch = ch; mon_seed = seed;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_hdr(input logic csi, input logic [2:0] sc);
        logic [6:0] v;
        logic [6:0] cw;
        v = {csi, sc, 3'b000};
        for (int b = 6; b >= 3; b--)
            if (v[b]) v = v ^ (7'b1011 << (b - 3));
        cw = {csi, sc, v[2:0]};
        return {cw, ^cw};
    endfunction

    task automatic tbl_write(input int idx, input logic v, input logic [7:0] vpi,
                             input logic [15:0] vci, input int ch);
        @(posedge clk); #1;
        tbl_we = 1'b1; tbl_idx = 2'(idx); tbl_valid = v;
        tbl_vpi = vpi; tbl_vci = vci; tbl_chan = 2'(ch);
        @(posedge clk); #1;
        tbl_we = 1'b0;
    endtask

    task automatic send_cell(input logic [7:0] vpi, input logic [15:0] vci,
                             input logic [7:0] hdr, input int seed,
                             input bit gaps, input int nbytes);
        for (int i = 0; i < nbytes; i++) begin
            if (gaps && (i % 5 == 2)) begin
                @(posedge clk); #1;
                in_valid = 1'b0; in_sop = 1'b0;
            end
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_sop   = (i == 0);
            case (i)
                0: in_byte = {4'h0, vpi[7:4]};
                1: in_byte = {vpi[3:0], vci[15:12]};
                2: in_byte = vci[11:4];
                3: in_byte = {vci[3:0], 4'h0};
                4: in_byte = 8'h00;
                5: in_byte = hdr;
                default: in_byte = 8'(seed + i - 6);
            endcase
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sop = 1'b0;
        repeat (4) @(posedge clk);
        #2;
    endtask

    task automatic clear_rdy();
        @(posedge clk); #1;
        rdy_clr = 4'hF;
        @(posedge clk); #1;
        rdy_clr = 4'h0;
    endtask

    typedef struct packed {
        logic [7:0]  vpi;
        logic [15:0] vci;
        logic        csi;
        logic [2:0]  sc;
        logic [7:0]  flip;
        logic        acc;
        logic [1:0]  ch;
        logic        fix;
        logic        bad;
        logic        miss;
        logic [3:0]  serr;
    } vec_t;

    localparam vec_t VEC [16] = '{
        '{8'd1, 16'h0020, 1'b0, 3'd0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 4'h0},
        '{8'd1, 16'h0020, 1'b1, 3'd1, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 4'h0},
        '{8'd1, 16'h0020, 1'b0, 3'd2, 8'h20, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 4'h0},
        '{8'd1, 16'h0020, 1'b1, 3'd3, 8'h01, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 4'h0},
        '{8'd1, 16'h0020, 1'b0, 3'd4, 8'h04, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 4'h0},
        '{8'd1, 16'h0020, 1'b0, 3'd6, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 4'h4},
        '{8'd1, 16'h0020, 1'b1, 3'd7, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 4'h0},
        '{8'd1, 16'h0020, 1'b0, 3'd0, 8'h50, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 4'h0},
        '{8'd1, 16'h0020, 1'b0, 3'd0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 4'h0},
        '{8'd5, 16'h0040, 1'b0, 3'd1, 8'h00, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 4'h0},
        '{8'd9, 16'h0099, 1'b0, 3'd1, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 4'h0},
        '{8'd3, 16'h1234, 1'b0, 3'd5, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 4'h0},
        '{8'd7, 16'hBEEF, 1'b1, 3'd3, 8'h80, 1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 4'h0},
        '{8'd1, 16'h0020, 1'b1, 3'd1, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 4'h0},
        '{8'd3, 16'h1234, 1'b0, 3'd5, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 4'h1},
        '{8'd1, 16'h0021, 1'b0, 3'd2, 8'h00, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 4'h0}
    };

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        mon_reset(0, 0);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        chk("R8 reset rdy", 32'(rdy), 0);
        chk("R7 reset wr_en", 32'(wr_en), 0);
        chk("R9 reset csi_valid", 32'(csi_valid), 0);
        chk("R6 reset seq_err", 32'(seq_err), 0);

        // R2: empty table after reset -> miss
        mon_reset(2, 0);
        send_cell(8'd1, 16'h0020, mk_hdr(1'b0, 3'd0), 0, 1'b0, 53);
        chk("R2 empty table miss", 32'(miss_n), 1);
        chk("R2 empty table no writes", 32'(wcnt), 0);

        tbl_write(0, 1'b1, 8'd1, 16'h0020, 2);
        tbl_write(1, 1'b1, 8'd3, 16'h1234, 0);
        tbl_write(2, 1'b0, 8'd5, 16'h0040, 1);
        tbl_write(3, 1'b1, 8'd7, 16'hBEEF, 3);

        for (int i = 0; i < 16; i++) begin
            vec_t v;
            v = VEC[i];
            mon_reset(int'(v.ch), i * 11);
            send_cell(v.vpi, v.vci, mk_hdr(v.csi, v.sc) ^ v.flip, i * 11, 1'b0, 53);
            chk($sformatf("R7 vec%0d write count", i), 32'(wcnt), v.acc ? 47 : 0);
            chk($sformatf("R7 vec%0d write addr/data", i), 32'(wbad), 0);
            chk($sformatf("R8 vec%0d rdy", i), 32'(rdy), v.acc ? 32'(4'b1 << v.ch) : 0);
            chk($sformatf("R9 vec%0d csi count", i), 32'(csi_n), v.acc ? 1 : 0);
            if (v.acc) begin
                chk($sformatf("R9 vec%0d csi bit", i), 32'(csi_seen), 32'(v.csi));
                chk($sformatf("R9 vec%0d csi chan", i), 32'(csich_seen), 32'(v.ch));
            end
            chk($sformatf("R4 vec%0d fix", i), 32'(fix_n), 32'(v.fix));
            chk($sformatf("R5 vec%0d bad", i), 32'(bad_n), 32'(v.bad));
            chk($sformatf("R1 vec%0d miss", i), 32'(miss_n), 32'(v.miss));
            chk($sformatf("R6 vec%0d seq_err", i), 32'(serr_seen), 32'(v.serr));
            if (v.acc && v.fix == 1'b0) chk($sformatf("R3 vec%0d clean accept", i), 32'(csi_n), 1);
            clear_rdy();
            #2;
            chk($sformatf("R8 vec%0d rdy cleared", i), 32'(rdy), 0);
        end

        // R8: flag holds until cleared
        mon_reset(0, 77);
        send_cell(8'd3, 16'h1234, mk_hdr(1'b0, 3'd6), 77, 1'b0, 53);
        repeat (10) @(posedge clk);
        #2;
        chk("R8 rdy held without clear", 32'(rdy), 32'h1);
        clear_rdy();

        // R10: stalls inside a cell
        mon_reset(0, 90);
        send_cell(8'd3, 16'h1234, mk_hdr(1'b1, 3'd7), 90, 1'b1, 53);
        chk("R10 gaps write count", 32'(wcnt), 47);
        chk("R10 gaps write addr/data", 32'(wbad), 0);
        chk("R10 gaps seq_err", 32'(serr_seen), 0);
        chk("R10 gaps rdy", 32'(rdy), 32'h1);
        clear_rdy();

        // R10: aborted cell then a full one
        mon_reset(2, 5);
        send_cell(8'd1, 16'h0020, mk_hdr(1'b0, 3'd2), 5, 1'b0, 20);
        chk("R10 aborted no rdy", 32'(rdy), 0);
        chk("R10 aborted partial writes", 32'(wcnt), 14);
        mon_reset(3, 33);
        send_cell(8'd7, 16'hBEEF, mk_hdr(1'b0, 3'd4), 33, 1'b0, 53);
        chk("R10 after abort write count", 32'(wcnt), 47);
        chk("R10 after abort write addr/data", 32'(wbad), 0);
        chk("R10 after abort rdy", 32'(rdy), 32'h8);
        clear_rdy();

        // R2: invalidating an entry makes its cells miss
        tbl_write(0, 1'b0, 8'd1, 16'h0020, 2);
        mon_reset(2, 0);
        send_cell(8'd1, 16'h0020, mk_hdr(1'b0, 3'd3), 0, 1'b0, 53);
        chk("R2 invalidated miss", 32'(miss_n), 1);
        chk("R1 invalidated no writes", 32'(wcnt), 0);
        chk("R1 invalidated no rdy", 32'(rdy), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule